// File: doc/BRIEF.md
# Configurable SPI Word Master

This block is a synchronous serial master that moves one data word per transfer, full duplex, between a parallel register-side interface and an external serial device. Software presents a transmit word and a configuration, then pulses `start`. The block asserts the chosen select lines and generates SCLK from the system clock through a programmable half-period divider. It shifts the transmit word out on MOSI while it assembles a received word from MISO. At the end it releases select, pulses `done` and presents the received word, right-justified.

The word length runs from 8 to 32 bits and the bit order is selectable. The SCLK idle level is programmable. The SCLK edge kind that moves MOSI and the kind that samples MISO are chosen independently. For full 32-bit words the block can hold SCLK idle for a programmable number of SCLK periods after every byte, with select kept asserted. Configuration and transmit data are captured at the accepted start, and inputs that change during a transfer have no effect on it.

Top module: `spi_word_master`

## Requirements
- R1: The word length is N = `nbits_m1` + 1 (5-bit field). Field values below 7 are treated as 7, giving N = 8. Every transfer produces exactly 2N SCLK transitions.
- R2: With `lsb_first` = 0, transmit bit N-1 goes out first and the first received bit lands in `rx_word` bit N-1. With `lsb_first` = 1, bit 0 goes first in both directions.
- R3: MOSI shows the first transmit bit from the cycle after start is accepted. It moves to the next bit only on SCLK transitions of the launch kind (`tx_fall` = 1: high-to-low, 0: low-to-high), and never on the first transition of a transfer.
- R4: MISO is sampled on SCLK transitions of the capture kind (`rx_fall` = 1: high-to-low, 0: low-to-high), chosen independently of R3. Each sample takes the MISO level present just before that transition, and exactly N samples are taken.
- R5: `rx_word` holds the N received bits in its low bits, with every higher bit zero. It is valid from the `done` cycle until the next accepted start.
- R6: While a transfer runs, `sel_n[i]` is low exactly when `sel_mask[i]` = 1 (mask captured at start). Outside a transfer both select outputs are high.
- R7: One SCLK half period is H = `half_div` + 1 system clock cycles. SCLK rests at the `cpol` level when idle. Select is asserted 2H cycles before the first SCLK transition and released H cycles after the last one.
- R8: `start` is accepted only while `busy` is low. `done` is a one-cycle pulse issued H*(2N+2+P) cycles after the accepting edge, where P is the number of pause half periods from R9. `busy` is high in between. A `start` or a change of any data or configuration input during a transfer does not affect that transfer.
- R9: With `susp_en` = 1, N = 32 and G = `susp_gap` nonzero, SCLK stays at its idle level for 2G half periods after transitions 16, 32 and 48, with select still asserted, so P = 6G. For any other N, or with G = 0, no pause is inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin-transfer strobe |
| tx_word | input | 32 | Word to transmit |
| nbits_m1 | input | 5 | Word length minus one |
| lsb_first | input | 1 | 1: least significant bit first |
| cpol | input | 1 | SCLK idle level |
| tx_fall | input | 1 | 1: MOSI moves on falling SCLK |
| rx_fall | input | 1 | 1: MISO sampled on falling SCLK |
| sel_mask | input | 2 | Select lines to assert |
| half_div | input | 8 | SCLK half period minus one, in clock cycles |
| susp_en | input | 1 | Enable inter-byte pauses |
| susp_gap | input | 4 | Pause length in SCLK periods |
| miso | input | 1 | Serial data from the device |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_word | output | 32 | Received word, right-justified |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data to the device |
| sel_n | output | 2 | Active-low device selects |

## Verification
The accepting edge is counted as edge 0. `done` is due on edge H*(2N+2+P), so the bench samples on falling edges and expects `done` on sample number H*(2N+2+P)+1. At that sample it checks `rx_word`, and it checks again one sample later, when `done` must be low and the word unchanged. SCLK's first transition is due on edge 2H, so select and the idle level are checked on every sample up to 2H. MISO is looped back from MOSI, optionally inverted. Transitions are counted across the whole transfer, and the expected word comes from an arithmetic walk over the 2N transitions using the launch and capture rules.

// File: rtl/spi_wm_pkg.sv
`timescale 1ns/1ps
package spi_wm_pkg;

    localparam int WORD_W     = 32;
    localparam int LEN_W      = $clog2(WORD_W);
    localparam int EDGE_W     = LEN_W + 1;
    localparam int SEL_W      = 2;
    localparam int DIV_W      = 8;
    localparam int GAP_W      = 4;
    localparam int MIN_BITS   = 8;
    localparam int BYTE_EDG_W = $clog2(2 * 8);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_SHIFT,
        ST_GAP,
        ST_TRAIL
    } seq_state_e;

    typedef struct packed {
        logic [LEN_W-1:0] nbits_m1;
        logic             lsb_first;
        logic             cpol;
        logic             tx_fall;
        logic             rx_fall;
        logic [SEL_W-1:0] sel_mask;
        logic [DIV_W-1:0] half_div;
        logic             susp_en;
        logic [GAP_W-1:0] susp_gap;
    } xfer_cfg_t;

    function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] m1);
        return (m1 < LEN_W'(MIN_BITS - 1)) ? LEN_W'(MIN_BITS - 1) : m1;
    endfunction

    function automatic logic [LEN_W-1:0] bit_pos(input logic [LEN_W-1:0] idx,
                                                 input logic [LEN_W-1:0] m1,
                                                 input logic             lsb);
        return lsb ? idx : (m1 - idx);
    endfunction

endpackage

// File: rtl/spi_wm_tick.sv
`timescale 1ns/1ps
module spi_wm_tick
    import spi_wm_pkg::*;
#(
    parameter int CNT_W = DIV_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             clear,
    input  logic [CNT_W-1:0] half_div,
    output logic             tick
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cnt_q <= '0;
        end else if (cnt_q == half_div) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign tick = run && (cnt_q == half_div);

    a_r7_div_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt_q <= half_div))
        else $error("a_r7_div_bound");

endmodule

// File: rtl/spi_wm_seq.sv
`timescale 1ns/1ps
module spi_wm_seq
    import spi_wm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             cpol_live,
    input  logic             tick,
    input  logic             cpol,
    input  logic             tx_fall,
    input  logic             rx_fall,
    input  logic             susp_en,
    input  logic [LEN_W-1:0] nbits_m1,
    input  logic [GAP_W-1:0] susp_gap,
    output logic             load,
    output logic             busy,
    output logic             done,
    output logic             sclk,
    output logic             launch,
    output logic             capture
);
    seq_state_e        state_q;
    logic [EDGE_W-1:0] edge_q;
    logic [GAP_W:0]    gap_q;
    logic              sclk_q;
    logic              done_q;
    logic [EDGE_W-1:0] last_edge;
    logic              byte_end;
    logic              gaps_on;
    logic              shift_tick;

    assign last_edge  = {nbits_m1, 1'b1};
    assign byte_end   = (edge_q[BYTE_EDG_W-1:0] == {BYTE_EDG_W{1'b1}});
    assign gaps_on    = susp_en && (nbits_m1 == LEN_W'(WORD_W - 1)) && (susp_gap != '0);
    assign shift_tick = tick && (state_q == ST_SHIFT);
    assign load       = start && (state_q == ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            edge_q  <= '0;
            gap_q   <= '0;
            sclk_q  <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    sclk_q <= cpol_live;
                    if (start) begin
                        state_q <= ST_LEAD;
                        edge_q  <= '0;
                    end
                end
                ST_LEAD: begin
                    if (tick) state_q <= ST_SHIFT;
                end
                ST_SHIFT: begin
                    if (tick) begin
                        sclk_q <= ~sclk_q;
                        edge_q <= edge_q + EDGE_W'(1);
                        if (edge_q == last_edge) begin
                            state_q <= ST_TRAIL;
                        end else if (byte_end && gaps_on) begin
                            state_q <= ST_GAP;
                            gap_q   <= {susp_gap, 1'b0};
                        end
                    end
                end
                ST_GAP: begin
                    if (tick) begin
                        if (gap_q == (GAP_W+1)'(1)) state_q <= ST_SHIFT;
                        gap_q <= gap_q - (GAP_W+1)'(1);
                    end
                end
                ST_TRAIL: begin
                    if (tick) begin
                        state_q <= ST_IDLE;
                        done_q  <= 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // The level before a transition tells its kind: high means falling.
    assign launch  = shift_tick && (sclk_q == tx_fall) && (edge_q != '0);
    assign capture = shift_tick && (sclk_q == rx_fall);
    assign busy    = (state_q != ST_IDLE);
    assign done    = done_q;
    assign sclk    = sclk_q;

    a_r7_sclk_parked: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_LEAD || state_q == ST_GAP || state_q == ST_TRAIL) |-> (sclk_q == cpol))
        else $error("a_r7_sclk_parked");

    a_r1_edge_bound: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SHIFT) |-> (edge_q <= last_edge))
        else $error("a_r1_edge_bound");

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done_q |=> !done_q)
        else $error("a_r8_done_single");

    a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (rst)
        done_q |-> (!busy && $past(busy)))
        else $error("a_r8_done_ends_busy");

    a_r9_gap_only_full: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_GAP) |-> (susp_en && nbits_m1 == LEN_W'(WORD_W - 1)))
        else $error("a_r9_gap_only_full");

endmodule

// File: rtl/spi_wm_datapath.sv
`timescale 1ns/1ps
module spi_wm_datapath
    import spi_wm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic              launch,
    input  logic              capture,
    input  logic              miso,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  load_m1,
    input  logic              load_lsb,
    input  logic [LEN_W-1:0]  m1,
    input  logic              lsb,
    output logic              mosi,
    output logic [WORD_W-1:0] rx_word,
    output logic [LEN_W:0]    rx_count
);
    logic [WORD_W-1:0] tx_q;
    logic [WORD_W-1:0] rx_q;
    logic [LEN_W:0]    tx_idx_q;
    logic [LEN_W:0]    rx_idx_q;
    logic [LEN_W:0]    tx_nxt;
    logic              mosi_q;

    assign tx_nxt = tx_idx_q + (LEN_W+1)'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q     <= '0;
            rx_q     <= '0;
            tx_idx_q <= '0;
            rx_idx_q <= '0;
            mosi_q   <= 1'b0;
        end else if (load) begin
            tx_q     <= tx_word;
            rx_q     <= '0;
            tx_idx_q <= '0;
            rx_idx_q <= '0;
            mosi_q   <= tx_word[bit_pos('0, load_m1, load_lsb)];
        end else begin
            if (launch && (tx_nxt <= {1'b0, m1})) begin
                tx_idx_q <= tx_nxt;
                mosi_q   <= tx_q[bit_pos(tx_nxt[LEN_W-1:0], m1, lsb)];
            end
            if (capture && (rx_idx_q <= {1'b0, m1})) begin
                rx_q[bit_pos(rx_idx_q[LEN_W-1:0], m1, lsb)] <= miso;
                rx_idx_q <= rx_idx_q + (LEN_W+1)'(1);
            end
        end
    end

    assign mosi     = mosi_q;
    assign rx_word  = rx_q;
    assign rx_count = rx_idx_q;

    a_r4_capture_bound: assert property (@(posedge clk) disable iff (rst)
        capture |-> (rx_idx_q <= {1'b0, m1}))
        else $error("a_r4_capture_bound");

    a_r3_launch_bound: assert property (@(posedge clk) disable iff (rst)
        (launch && !load) |-> (tx_idx_q <= {1'b0, m1}))
        else $error("a_r3_launch_bound");

endmodule

// File: rtl/spi_word_master.sv
`timescale 1ns/1ps
module spi_word_master
    import spi_wm_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [WORD_W-1:0] tx_word,
    input  logic [LEN_W-1:0]  nbits_m1,
    input  logic              lsb_first,
    input  logic              cpol,
    input  logic              tx_fall,
    input  logic              rx_fall,
    input  logic [SEL_W-1:0]  sel_mask,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              susp_en,
    input  logic [GAP_W-1:0]  susp_gap,
    input  logic              miso,
    output logic              busy,
    output logic              done,
    output logic [WORD_W-1:0] rx_word,
    output logic              sclk,
    output logic              mosi,
    output logic [SEL_W-1:0]  sel_n
);
    xfer_cfg_t      cfg_in;
    xfer_cfg_t      cfg_q;
    logic           load;
    logic           tick;
    logic           launch;
    logic           capture;
    logic [LEN_W:0] rx_count;

    always_comb begin
        cfg_in.nbits_m1  = clamp_len(nbits_m1);
        cfg_in.lsb_first = lsb_first;
        cfg_in.cpol      = cpol;
        cfg_in.tx_fall   = tx_fall;
        cfg_in.rx_fall   = rx_fall;
        cfg_in.sel_mask  = sel_mask;
        cfg_in.half_div  = half_div;
        cfg_in.susp_en   = susp_en;
        cfg_in.susp_gap  = susp_gap;
    end

    always_ff @(posedge clk) begin
        if (rst)       cfg_q <= '0;
        else if (load) cfg_q <= cfg_in;
    end

    spi_wm_tick #(.CNT_W(DIV_W)) tick_i (
        .clk      (clk),
        .rst      (rst),
        .run      (busy),
        .clear    (load),
        .half_div (cfg_q.half_div),
        .tick     (tick)
    );

    spi_wm_seq seq_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cpol_live (cpol),
        .tick      (tick),
        .cpol      (cfg_q.cpol),
        .tx_fall   (cfg_q.tx_fall),
        .rx_fall   (cfg_q.rx_fall),
        .susp_en   (cfg_q.susp_en),
        .nbits_m1  (cfg_q.nbits_m1),
        .susp_gap  (cfg_q.susp_gap),
        .load      (load),
        .busy      (busy),
        .done      (done),
        .sclk      (sclk),
        .launch    (launch),
        .capture   (capture)
    );

    spi_wm_datapath dp_i (
        .clk      (clk),
        .rst      (rst),
        .load     (load),
        .launch   (launch),
        .capture  (capture),
        .miso     (miso),
        .tx_word  (tx_word),
        .load_m1  (cfg_in.nbits_m1),
        .load_lsb (cfg_in.lsb_first),
        .m1       (cfg_q.nbits_m1),
        .lsb      (cfg_q.lsb_first),
        .mosi     (mosi),
        .rx_word  (rx_word),
        .rx_count (rx_count)
    );

    assign sel_n = busy ? ~cfg_q.sel_mask : {SEL_W{1'b1}};

    a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
        done |-> ((rx_word >> ({1'b0, cfg_q.nbits_m1} + (LEN_W+1)'(1))) == '0))
        else $error("a_r5_upper_zero");

    a_r4_all_bits: assert property (@(posedge clk) disable iff (rst)
        done |-> (rx_count == ({1'b0, cfg_q.nbits_m1} + (LEN_W+1)'(1))))
        else $error("a_r4_all_bits");

    a_r6_sel_steady: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(sel_n))
        else $error("a_r6_sel_steady");

    a_r8_cfg_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q))
        else $error("a_r8_cfg_frozen");

endmodule

// File: tb/spi_word_master_tb.sv
`timescale 1ns/1ps
module spi_word_master_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [31:0] tx_word = '0;
    logic [4:0]  nbits_m1 = 5'd7;
    logic        lsb_first = 1'b0;
    logic        cpol = 1'b1;
    logic        tx_fall = 1'b0;
    logic        rx_fall = 1'b0;
    logic [1:0]  sel_mask = 2'b00;
    logic [7:0]  half_div = 8'd1;
    logic        susp_en = 1'b0;
    logic [3:0]  susp_gap = 4'd0;
    logic        inv = 1'b0;
    logic        miso;
    logic        busy, done, sclk, mosi;
    logic [31:0] rx_word;
    logic [1:0]  sel_n;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    assign miso = mosi ^ inv;

    spi_word_master dut_i (
        .clk(clk), .rst(rst), .start(start), .tx_word(tx_word),
        .nbits_m1(nbits_m1), .lsb_first(lsb_first), .cpol(cpol),
        .tx_fall(tx_fall), .rx_fall(rx_fall), .sel_mask(sel_mask),
        .half_div(half_div), .susp_en(susp_en), .susp_gap(susp_gap),
        .miso(miso), .busy(busy), .done(done), .rx_word(rx_word),
        .sclk(sclk), .mosi(mosi), .sel_n(sel_n)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Walk the 2N transitions: capture takes the level before the transition,
    // launch moves the bit pointer but never on the first transition.
    function automatic logic [31:0] model_rx(input logic [31:0] tx, input int n,
                                             input bit lsb, input bit pol,
                                             input bit tf, input bit rf, input bit iv);
        logic [31:0] r = '0;
        int ti = 0;
        int ri = 0;
        bit lvl = pol;
        for (int e = 0; e < 2 * n; e++) begin
            if (lvl == rf && ri < n) begin
                r[lsb ? ri : n - 1 - ri] = tx[lsb ? ti : n - 1 - ti] ^ iv;
                ri++;
            end
            if (lvl == tf && e != 0 && ti + 1 < n) ti++;
            lvl = ~lvl;
        end
        return r;
    endfunction

    task automatic run_xfer(input logic [31:0] tx, input int m1, input bit lsb,
                            input bit pol, input bit tf, input bit rf,
                            input logic [1:0] mask, input int hd, input bit sen,
                            input int sg, input bit iv, input bit mid);
        int n, h, ng, exp_cyc, cyc, tog;
        bit prev, lead_bad, sel_bad, busy_bad;
        logic [31:0] exp_rx, got;
        n  = ((m1 < 7) ? 7 : m1) + 1;
        h  = hd + 1;
        ng = (sen && n == 32 && sg != 0) ? 3 : 0;
        exp_cyc = h * (2 * n + 2 + 2 * sg * ng) + 1;
        exp_rx  = model_rx(tx, n, lsb, pol, tf, rf, iv);
        @(negedge clk);
        tx_word = tx; nbits_m1 = 5'(m1); lsb_first = lsb; cpol = pol;
        tx_fall = tf; rx_fall = rf; sel_mask = mask; half_div = 8'(hd);
        susp_en = sen; susp_gap = 4'(sg); inv = iv;
        @(negedge clk);
        prev = sclk;
        start = 1'b1;
        cyc = 0; tog = 0; lead_bad = 0; sel_bad = 0; busy_bad = 0;
        while (cyc < 8000) begin
            @(negedge clk);
            cyc++;
            if (cyc == 1) start = 1'b0;
            if (mid && cyc == 5) begin
                start = 1'b1; tx_word = ~tx; nbits_m1 = 5'd15; sel_mask = ~mask;
                lsb_first = ~lsb; tx_fall = ~tf; rx_fall = ~rf; susp_gap = 4'd9;
            end
            if (mid && cyc == 6) start = 1'b0;
            if (sclk != prev) tog++;
            prev = sclk;
            if (done) break;
            if (sel_n != ~mask) sel_bad = 1;
            if (!busy) busy_bad = 1;
            if (cyc <= 2 * h && sclk != pol) lead_bad = 1;
        end
        chk(cyc == exp_cyc, "R8/R9 done timing", cyc, exp_cyc);
        chk(tog == 2 * n, "R1 sclk transitions", tog, 2 * n);
        chk(rx_word == exp_rx, "R2/R3/R4/R5 rx_word", rx_word, exp_rx);
        chk(!sel_bad && sel_n == 2'b11, "R6 select during/after", sel_n, 2'b11);
        chk(!lead_bad && sclk == pol, "R7 idle level and lead", sclk, pol);
        chk(!busy_bad && !busy, "R8 busy window", busy, 0);
        got = rx_word;
        @(negedge clk);
        chk(!done && rx_word == got, "R5/R8 done pulse, word held", rx_word, got);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        chk(sel_n == 2'b11, "R6 reset select", sel_n, 2'b11);
        chk(!busy && !done, "R8 reset idle", {busy, done}, 0);
        chk(rx_word == 32'h0, "R5 reset word", rx_word, 0);
        chk(sclk == 1'b1, "R7 idle follows cpol", sclk, 1);

        // Sweep: every length, order, idle level, launch and capture kind.
        for (int m = 7; m < 32; m++) begin
            for (int c = 0; c < 16; c++) begin
                run_xfer(32'hA5C3_96E1 ^ (32'(m) * 32'h0101_0101) ^ (32'(c) << 20),
                         m, c[0], c[1], c[2], c[3], 2'(m + c), 1, 1'b0, 0,
                         1'(m + c), 1'b0);
            end
        end
        // R1 clamp: short field treated as 8 bits, fastest divider.
        run_xfer(32'h0000_01B7, 3, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 0, 1'b0, 0, 1'b0, 1'b0);
        run_xfer(32'h0000_00C4, 0, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 0, 1'b0, 0, 1'b1, 1'b0);
        // R7 slower divider.
        run_xfer(32'h0000_0E5A, 11, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 4, 1'b0, 0, 1'b0, 1'b0);
        // R9 pauses on a full word, and no pause cases.
        run_xfer(32'hDEAD_BEEF, 31, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 1, 1'b1, 3, 1'b0, 1'b0);
        run_xfer(32'h1234_5678, 31, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 2, 1'b1, 15, 1'b1, 1'b0);
        run_xfer(32'h0F0F_3C3C, 31, 1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 1, 1'b1, 0, 1'b0, 1'b0);
        run_xfer(32'h5555_AAAA, 30, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 1, 1'b1, 5, 1'b0, 1'b0);
        run_xfer(32'h8001_7FFE, 31, 1'b0, 1'b1, 1'b1, 1'b1, 2'b10, 1, 1'b0, 5, 1'b1, 1'b0);
        // R8 start and input changes while busy have no effect.
        run_xfer(32'h00C3_A55A, 23, 1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 1, 1'b0, 0, 1'b0, 1'b1);
        run_xfer(32'hC001_D00D, 31, 1'b1, 1'b1, 1'b0, 1'b1, 2'b10, 0, 1'b1, 2, 1'b1, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule